// File: doc/BRIEF.md
# Double-Buffered DAC Code Register

This block keeps the 12-bit level code for an auxiliary digital-to-analog converter. Software updates the code one byte at a time over a narrow register bus. Each byte write lands in a shadow copy of the code, and the converter keeps running on its old value. A separate one-cycle latch strobe, which comes from a command register elsewhere, moves the whole shadow word into the output register in one step. The converter therefore never sees a half-written code.

The code takes two byte addresses. The low byte sits at the base address and the high byte at base plus one. Both bytes can be written and read back, and readback always shows the shadow copy. The upper four bits of the high byte do not exist: they are dropped on a write and read as zero. The contents are volatile. Any reset returns both the shadow and the output to zero. The reset input is asserted asynchronously and released in step with the clock.

Top module: `dacreg_top`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0 and reads of 0x30 and 0x31 return 0. After release, both stay 0 until something is written.
- R2: A write to address 0x30 loads `wr_data[7:0]` into shadow bits 7:0. A read of 0x30 shows the new byte starting in the cycle after the write edge.
- R3: A write to address 0x31 keeps only `wr_data[3:0]`, which become shadow bits 11:8. A read of 0x31 returns {4'b0000, shadow[11:8]}.
- R4: `dac_code` holds its value through any number of byte writes while `latch_strb` is low.
- R5: `dac_code` equals the shadow word from before an edge at which `latch_strb` is high, starting in the cycle after that edge. The whole 12-bit word moves in a single cycle.
- R6: A latch strobe with no byte write since the previous latch leaves `dac_code` unchanged.
- R7: When a byte write and `latch_strb` fall on the same edge, `dac_code` takes the shadow value from before that write. The write still reaches the shadow.
- R8: A write to any address other than 0x30 or 0x31 changes neither the shadow nor `dac_code`. A read of any such address returns 0.
- R9: A reset asserted in the middle of operation clears both the shadow and `dac_code` to 0 at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Byte address of the write |
| wr_data | input | 8 | Byte to write |
| rd_addr | input | 8 | Byte address of the read |
| rd_data | output | 8 | Readback byte from the shadow copy (combinational) |
| latch_strb | input | 1 | One-cycle command that moves the shadow word to the output |
| dac_code | output | 12 | Code applied to the converter |

## Verification
The bench drives three kinds of stimulus:
- **Split byte writes with no latch.** These show that the shadow and the output are separate (R4). Writing 0xFB to the high byte shows the dropped upper bits on readback (R3).
- **Latches with and without pending writes.** These show a real transfer apart from a repeated one (R5, R6).
- **A write and a latch on the same edge.** This shows whether the copy takes the old or the new shadow value (R7).

Stray addresses next to the register, a reset in the middle of operation, and a long random mix of writes, latches and reads are each compared on every clock against a behavioural model.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  localparam int BYTE_W = 8;

  function automatic int lanes_for(input int bits);
    return (bits + BYTE_W - 1) / BYTE_W;
  endfunction

  function automatic int lane_width(input int bits, input int lane);
    int rest;
    rest = bits - lane * BYTE_W;
    return (rest >= BYTE_W) ? BYTE_W : rest;
  endfunction
endpackage

// File: rtl/dacreg_rst_sync.sv
module dacreg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/dacreg_shadow.sv
module dacreg_shadow
  import dacreg_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  output logic [CODE_W-1:0] shadow_o
);
  localparam int NUM_LANES = lanes_for(CODE_W);

  logic [BYTE_W-1:0] lane_rd [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    localparam int LW = lane_width(CODE_W, g);
    localparam logic [ADDR_W-1:0] LANE_ADDR = ADDR_W'(BASE_ADDR + g);

    logic [LW-1:0] lane_q;
    logic [LW-1:0] lane_d;
    logic          lane_we;
    logic [BYTE_W-1:0] lane_ext;

    assign lane_we = wr_en && (wr_addr == LANE_ADDR);

    always_comb begin
      lane_d = lane_q;
      if (lane_we) lane_d = wr_data[LW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lane_q <= '0;
      else        lane_q <= lane_d;
    end

    always_comb begin
      lane_ext = '0;
      lane_ext[LW-1:0] = lane_q;
      lane_rd[g] = (rd_addr == LANE_ADDR) ? lane_ext : '0;
    end

    assign shadow_o[g*BYTE_W +: LW] = lane_q;
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_LANES; k++) rd_data = rd_data | lane_rd[k];
  end
endmodule

// File: rtl/dacreg_hold.sv
module dacreg_hold #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_strb,
  input  logic [CODE_W-1:0] shadow_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;

  always_comb begin
    code_d = code_q;
    if (latch_strb) code_d = shadow_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/dacreg_top.sv
module dacreg_top
  import dacreg_pkg::*;
#(
  parameter int CODE_W      = 12,
  parameter int ADDR_W      = 8,
  parameter int BASE_ADDR   = 'h30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              latch_strb,
  output logic [CODE_W-1:0] dac_code
);
  logic              rst_n_sync;
  logic [CODE_W-1:0] shadow_w;

  dacreg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  dacreg_shadow #(
    .CODE_W    (CODE_W),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .shadow_o (shadow_w)
  );

  dacreg_hold #(.CODE_W(CODE_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .latch_strb (latch_strb),
    .shadow_i   (shadow_w),
    .code_o     (dac_code)
  );
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk
  import dacreg_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_n_sync,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [BYTE_W-1:0] wr_data,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BYTE_W-1:0] rd_data,
  input logic              latch_strb,
  input logic [CODE_W-1:0] dac_code,
  input logic [CODE_W-1:0] shadow
);
  localparam int NUM_LANES = lanes_for(CODE_W);
  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + NUM_LANES - 1);
  localparam int TOP_LW = lane_width(CODE_W, NUM_LANES - 1);

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> (dac_code == '0 && shadow == '0)); // R1

  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (wr_en && wr_addr == LO_A) |=> shadow[BYTE_W-1:0] == $past(wr_data)); // R2

  AST_HIGH_READ_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == HI_A) |-> rd_data[BYTE_W-1:TOP_LW] == '0); // R3

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !latch_strb |=> $stable(dac_code)); // R4

  AST_LATCH_COPY: assert property (@(posedge clk) disable iff (!rst_n_sync)
    latch_strb |=> dac_code == $past(shadow)); // R5

  AST_STRAY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr < LO_A || rd_addr > HI_A) |-> rd_data == '0); // R8

  AST_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (!(wr_en && wr_addr >= LO_A && wr_addr <= HI_A)) |=> $stable(shadow)); // R8
endmodule

bind dacreg_top dacreg_chk #(
  .CODE_W    (CODE_W),
  .ADDR_W    (ADDR_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_n_sync (rst_n_sync),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_addr    (rd_addr),
  .rd_data    (rd_data),
  .latch_strb (latch_strb),
  .dac_code   (dac_code),
  .shadow     (shadow_w)
);

// File: tb/test_dacreg_top.sv
module test_dacreg_top;
  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_data;
  logic [7:0]  rd_addr;
  logic [7:0]  rd_data;
  logic        latch_strb;
  logic [11:0] dac_code;

  int n_run;
  int n_fail;
  bit done;

  // behavioural model
  int m_shadow;
  int m_code;
  int m_rst_cnt;

  dacreg_top i_dacreg_top (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .latch_strb (latch_strb),
    .dac_code   (dac_code)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic int model_read(input int a);
    if (a == 'h30) return m_shadow & 'hFF;
    if (a == 'h31) return (m_shadow >> 8) & 'hF;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge rst_n) begin
    m_shadow  = 0;
    m_code    = 0;
    m_rst_cnt = 0;
  end

  always @(posedge clk) begin
    int nxt_shadow;
    if (!rst_n) begin
      m_shadow = 0; m_code = 0; m_rst_cnt = 0;
    end else if (m_rst_cnt < 2) begin
      m_rst_cnt++;
    end else begin
      nxt_shadow = m_shadow;
      if (wr_en && wr_addr == 8'h30) nxt_shadow = (m_shadow & 'hF00) | int'(wr_data);
      if (wr_en && wr_addr == 8'h31) nxt_shadow = (m_shadow & 'h0FF) | ((int'(wr_data) & 'hF) << 8);
      if (latch_strb) m_code = m_shadow;
      m_shadow = nxt_shadow;
    end
    #(CLK_P/4);
    if (!done) begin
      check(int'(dac_code) == m_code, "R5 model dac_code", int'(dac_code), m_code);
      check(int'(rd_data) == model_read(int'(rd_addr)), "R2 model readback",
            int'(rd_data), model_read(int'(rd_addr)));
    end
  end

  task automatic idle();
    wr_en = 1'b0; latch_strb = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input bit lat);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; latch_strb = lat;
    @(negedge clk);
    idle();
  endtask

  task automatic do_latch();
    @(negedge clk);
    latch_strb = 1'b1;
    @(negedge clk);
    idle();
  endtask

  task automatic read_chk(input logic [7:0] a, input int exp, input string req);
    rd_addr = a;
    #1;
    check(int'(rd_data) == exp, req, int'(rd_data), exp);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    n_run++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_up();
  end

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    m_shadow = 0; m_code = 0; m_rst_cnt = 0;
    rst_n = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = 8'h30; latch_strb = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(dac_code == 12'h000, "R1 reset code", int'(dac_code), 0);
    read_chk(8'h30, 0, "R1 reset low byte");
    read_chk(8'h31, 0, "R1 reset high byte");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(dac_code == 12'h000, "R1 after release", int'(dac_code), 0);

    do_write(8'h30, 8'hA5, 1'b0);
    read_chk(8'h30, 'hA5, "R2 low byte readback");
    check(dac_code == 12'h000, "R4 code held after low write", int'(dac_code), 0);

    do_write(8'h31, 8'hFB, 1'b0);
    read_chk(8'h31, 'h0B, "R3 high byte masked");
    check(dac_code == 12'h000, "R4 code held after high write", int'(dac_code), 0);

    do_latch();
    check(dac_code == 12'hBA5, "R5 latch transfer", int'(dac_code), 'hBA5);

    do_latch();
    check(dac_code == 12'hBA5, "R6 repeat latch no change", int'(dac_code), 'hBA5);

    do_write(8'h30, 8'h12, 1'b1);
    check(dac_code == 12'hBA5, "R7 same-edge latch takes old shadow", int'(dac_code), 'hBA5);
    read_chk(8'h30, 'h12, "R7 same-edge write reaches shadow");
    do_latch();
    check(dac_code == 12'hB12, "R7 later latch takes new byte", int'(dac_code), 'hB12);

    do_write(8'h32, 8'hFF, 1'b0);
    do_write(8'h2F, 8'h77, 1'b0);
    read_chk(8'h30, 'h12, "R8 stray write low untouched");
    read_chk(8'h31, 'h0B, "R8 stray write high untouched");
    read_chk(8'h32, 0, "R8 stray read zero");
    do_latch();
    check(dac_code == 12'hB12, "R8 stray write no code effect", int'(dac_code), 'hB12);

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(dac_code == 12'h000, "R9 mid reset code", int'(dac_code), 0);
    read_chk(8'h30, 0, "R9 mid reset low");
    read_chk(8'h31, 0, "R9 mid reset high");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      wr_en      = ($urandom_range(0, 1) == 1);
      wr_addr    = 8'(8'h2E + $urandom_range(0, 5));
      wr_data    = 8'($urandom_range(0, 255));
      latch_strb = ($urandom_range(0, 3) == 0);
      rd_addr    = 8'(8'h2E + $urandom_range(0, 5));
    end
    @(negedge clk);
    idle();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule